// File: doc/BRIEF.md
# Message-Signalled Interrupt Source Controller

This block collects a set of numbered interrupt sources and forwards them to a downstream interrupt file as message-signalled writes. Each source has its own trigger mode (level or rising edge), an enable bit, and a target register. The target register says which hart, which hart group and which interrupt identity the message should carry. Software reaches all of this through a simple 32-bit register bus. Sources are switched on and off by writing a source number to a set register or a clear register, so no read-modify-write of a bitmap is needed.

When a source becomes pending, the pending flag is kept even while the source or the domain is switched off. Once delivery is permitted, the lowest-numbered eligible source wins. The controller forms a write address and a data word and holds them on the message port until the receiver accepts them. Launching a message clears the pending flag of that source.

Top module: `msi_src_ctrl`

## Requirements
- R1: After reset the domain register reads 0, every target and mode register reads 0, every source is disabled and msiValid is 0.
- R2: The domain register at offset 0x0000 keeps bit 8 (domain enable) and bit 2 (message mode). Its other bits read as zero.
- R3: Writing N to offset 0x1000 enables source N, and writing N to offset 0x1004 disables it, for N from 1 to NUM_SRC. Both offsets read as zero. A written value of 0 or above NUM_SRC changes no enable.
- R4: The target register of source N sits at 0x3000+4N. The identity is in bits ID_W-1:0, the hart index starts at bit 18 and is HART_W wide, and the group index is GROUP_W wide directly above the hart index. All other bits read as zero.
- R5: A message is launched only when the domain enable is 1, the message mode is 1, and the source is both enabled and pending.
- R6: The message address is BASE_ADDR + (hart << 12) + (group << GROUP_SHIFT). The message data is the identity, zero-extended.
- R7: Launching a message clears that source's pending flag. One rising edge on an edge-mode source produces exactly one message.
- R8: A level-mode source whose input stays high is delivered again after every accepted message. Once the input is low and the flags already latched are drained, no further message appears.
- R9: When several sources are eligible at once, they are delivered in ascending source-number order.
- R10: While msiValid is 1 and msiReady is 0, msiValid stays 1 and msiAddr and msiData stay stable.
- R11: An event that arrives while its source is disabled, or while the domain is off, stays pending and is delivered once delivery is allowed.
- R12: The mode register of source N sits at offset 4N. Bit 0 selects rising-edge trigger (1) or level-high trigger (0), and the other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 16 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| srcIn | input | NUM_SRC | Interrupt inputs; bit i is source i+1 |
| msiValid | output | 1 | Message write request |
| msiReady | input | 1 | Receiver accepts the message |
| msiAddr | output | 32 | Message write address |
| msiData | output | 32 | Message write data (identity) |

## Verification
The bench goes after several corner cases. It checks that events arriving while a source is disabled, or while either domain bit is clear, are kept; a design that dropped them would stay silent after the enable. It checks that edge sources fire exactly once; a design that failed to clear pending on launch would repeat messages forever. It checks that by-number writes of 0 or of an out-of-range value do nothing; a design that used only the low bits for decoding would enable a wrong source. It also sweeps every source's target fields with junk in the unused bits and checks the computed address. This exposes shifted fields, a misplaced group index, and delivery out of ascending order when many sources are pending at once.

// File: rtl/msisrc_pkg.sv
package msisrc_pkg;

  localparam int SRC_IDX_W = 10;

  localparam logic [15:0] OFS_DOMAIN = 16'h0000;
  localparam logic [15:0] OFS_SET_EN = 16'h1000;
  localparam logic [15:0] OFS_CLR_EN = 16'h1004;
  localparam int          OFS_TARGET = 'h3000;

  localparam int DOM_IE_BIT = 8;
  localparam int DOM_DM_BIT = 2;
  localparam int HART_LSB   = 18;
  localparam int PAGE_SHIFT = 12;

  typedef struct packed {
    logic                 launch;
    logic [SRC_IDX_W-1:0] src;
  } strobe_t;

endpackage

// File: rtl/msisrc_dp.sv
module msisrc_dp
  import msisrc_pkg::*;
#(
  parameter int          NUM_SRC     = 8,
  parameter int          ID_W        = 11,
  parameter int          HART_W      = 4,
  parameter int          GROUP_W     = 3,
  parameter int          GROUP_SHIFT = 24,
  parameter logic [31:0] BASE_ADDR   = 32'h2400_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [15:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  input  strobe_t            strb,
  output logic [NUM_SRC-1:0] eligible,
  output logic               domOn,
  output logic [31:0]        msiAddr,
  output logic [31:0]        msiData
);

  localparam int GRP_LSB = HART_LSB + HART_W;

  logic               ieQ, dmQ;
  logic [NUM_SRC-1:0] enQ, edgeQ, pendQ, prevQ;
  logic [ID_W-1:0]    idQ    [NUM_SRC];
  logic [HART_W-1:0]  hartQ  [NUM_SRC];
  logic [GROUP_W-1:0] groupQ [NUM_SRC];
  logic [31:0]        msiAddrQ, msiDataQ;

  logic               wrEn;
  logic [NUM_SRC-1:0] cfgHit, tgtHit, setHit, clrHit, evt, launchHit;

  assign wrEn  = busValid && busWrite;
  assign domOn = ieQ && dmQ;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign cfgHit[g]    = busAddr == 16'(4 * (g + 1));
    assign tgtHit[g]    = busAddr == 16'(OFS_TARGET + 4 * (g + 1));
    assign setHit[g]    = wrEn && busAddr == OFS_SET_EN && busWdata == 32'(g + 1);
    assign clrHit[g]    = wrEn && busAddr == OFS_CLR_EN && busWdata == 32'(g + 1);
    assign evt[g]       = edgeQ[g] ? (srcIn[g] && !prevQ[g]) : srcIn[g];
    assign launchHit[g] = strb.launch && strb.src == SRC_IDX_W'(g + 1);
    assign eligible[g]  = pendQ[g] && enQ[g] && domOn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ieQ <= 1'b0;
      dmQ <= 1'b0;
    end else if (wrEn && busAddr == OFS_DOMAIN) begin
      ieQ <= busWdata[DOM_IE_BIT];
      dmQ <= busWdata[DOM_DM_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= '0;
      edgeQ <= '0;
      pendQ <= '0;
      prevQ <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        idQ[i]    <= '0;
        hartQ[i]  <= '0;
        groupQ[i] <= '0;
      end
    end else begin
      prevQ <= srcIn;
      // a new event in the launch cycle survives the clear
      pendQ <= (pendQ & ~launchHit) | evt;
      enQ   <= (enQ | setHit) & ~clrHit;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (wrEn && cfgHit[i]) edgeQ[i] <= busWdata[0];
        if (wrEn && tgtHit[i]) begin
          idQ[i]    <= busWdata[ID_W-1:0];
          hartQ[i]  <= busWdata[HART_LSB +: HART_W];
          groupQ[i] <= busWdata[GRP_LSB +: GROUP_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msiAddrQ <= '0;
      msiDataQ <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (launchHit[i]) begin
          msiAddrQ <= BASE_ADDR + (32'(hartQ[i]) << PAGE_SHIFT)
                                + (32'(groupQ[i]) << GROUP_SHIFT);
          msiDataQ <= 32'(idQ[i]);
        end
      end
    end
  end

  assign msiAddr = msiAddrQ;
  assign msiData = msiDataQ;

  always_comb begin
    busRdata = '0;
    if (busAddr == OFS_DOMAIN) begin
      busRdata[DOM_IE_BIT] = ieQ;
      busRdata[DOM_DM_BIT] = dmQ;
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cfgHit[i]) busRdata = {31'b0, edgeQ[i]};
      if (tgtHit[i]) begin
        busRdata = '0;
        busRdata[ID_W-1:0]          = idQ[i];
        busRdata[HART_LSB +: HART_W] = hartQ[i];
        busRdata[GRP_LSB +: GROUP_W] = groupQ[i];
      end
    end
  end

endmodule

// File: rtl/msisrc_ctl.sv
module msisrc_ctl
  import msisrc_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] eligible,
  input  logic               msiReady,
  output strobe_t            strb,
  output logic               msiValid
);

  logic                 busyQ;
  logic [SRC_IDX_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) pick = SRC_IDX_W'(i + 1);
    end
  end

  assign strb.launch = (|eligible) && !busyQ;
  assign strb.src    = pick;

  always_ff @(posedge clk) begin
    if (!rstN)             busyQ <= 1'b0;
    else if (strb.launch)  busyQ <= 1'b1;
    else if (msiReady)     busyQ <= 1'b0;
  end

  assign msiValid = busyQ;

endmodule

// File: rtl/msi_src_ctrl.sv
module msi_src_ctrl
  import msisrc_pkg::*;
#(
  parameter int          NUM_SRC     = 8,
  parameter int          ID_W        = 11,
  parameter int          HART_W      = 4,
  parameter int          GROUP_W     = 3,
  parameter int          GROUP_SHIFT = 24,
  parameter logic [31:0] BASE_ADDR   = 32'h2400_0000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [15:0]        busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               msiValid,
  input  logic               msiReady,
  output logic [31:0]        msiAddr,
  output logic [31:0]        msiData
);

  strobe_t            strb;
  logic [NUM_SRC-1:0] eligible;
  logic               domOn;

  msisrc_dp #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W), .HART_W(HART_W), .GROUP_W(GROUP_W),
    .GROUP_SHIFT(GROUP_SHIFT), .BASE_ADDR(BASE_ADDR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcIn), .strb(strb), .eligible(eligible), .domOn(domOn),
    .msiAddr(msiAddr), .msiData(msiData)
  );

  msisrc_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .msiReady(msiReady),
    .strb(strb), .msiValid(msiValid)
  );

endmodule

// File: rtl/msisrc_chk.sv
module msisrc_chk #(
  parameter logic [31:0] BASE_ADDR = 32'h2400_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [15:0] busAddr,
  input logic [31:0] busRdata,
  input logic        msiValid,
  input logic        msiReady,
  input logic [31:0] msiAddr,
  input logic [31:0] msiData,
  input logic        launch,
  input logic        domOn
);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    msiValid && !msiReady |=> msiValid && $stable(msiAddr) && $stable(msiData)); // R10

  AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    launch |-> !msiValid); // R10

  AST_DOMAIN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msiValid) |-> $past(domOn)); // R5

  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    msiValid |-> msiAddr[11:0] == BASE_ADDR[11:0]); // R6

  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && (busAddr == 16'h1000 || busAddr == 16'h1004)
      |-> busRdata == 32'h0); // R3

endmodule

bind msi_src_ctrl msisrc_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .msiValid(msiValid),
  .msiReady(msiReady), .msiAddr(msiAddr), .msiData(msiData),
  .launch(strb.launch), .domOn(domOn)
);

// File: tb/sim_msi_src_ctrl.sv
module sim_msi_src_ctrl;

  localparam int          NSRC = 8;
  localparam logic [31:0] BASE = 32'h2400_0000;
  localparam int          GSH  = 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NSRC-1:0] srcIn = '0;
  logic        msiValid, msiReady = 1'b0;
  logic [31:0] msiAddr, msiData;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  msi_src_ctrl u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcIn(srcIn), .msiValid(msiValid), .msiReady(msiReady),
    .msiAddr(msiAddr), .msiData(msiData)
  );

  function automatic logic [31:0] idOf(int n);   return 32'(40 + 3 * n); endfunction
  function automatic logic [31:0] hartOf(int n); return 32'((5 * n) % 16); endfunction
  function automatic logic [31:0] grpOf(int n);  return 32'((3 * n) % 8); endfunction
  function automatic logic [31:0] tgtVal(int n);
    return idOf(n) | (hartOf(n) << 18) | (grpOf(n) << 22);
  endfunction
  function automatic logic [31:0] expAddr(int n);
    return BASE + (hartOf(n) << 12) + (grpOf(n) << GSH);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busValid = 0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk); srcIn = m;
    @(negedge clk); srcIn = '0;
  endtask

  task automatic waitMsi(input int maxCyc, output bit got);
    got = 0;
    for (int k = 0; k < maxCyc && !got; k++) begin
      @(negedge clk);
      if (msiValid) got = 1;
    end
  endtask

  task automatic ack();
    msiReady = 1;
    @(negedge clk);
    msiReady = 0;
  endtask

  task automatic expectMsg(input int n, input string tag, input bit holdChk);
    bit got;
    logic [31:0] a, d;
    waitMsi(20, got);
    chk(got, tag, 32'(got), 1);
    if (got) begin
      chk(msiAddr == expAddr(n), "R6 addr", msiAddr, expAddr(n));
      chk(msiData == idOf(n), tag, msiData, idOf(n));
      if (holdChk) begin
        a = msiAddr; d = msiData;
        repeat (3) @(negedge clk);
        chk(msiValid && msiAddr == a && msiData == d, "R10 hold", msiAddr, a);
      end
      ack();
    end
  endtask

  task automatic expectNone(input string tag);
    bit got;
    waitMsi(10, got);
    chk(!got, tag, msiData, 0);
    if (got) ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    bit got;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd(16'h0000, r);           chk(r == 0, "R1 domain", r, 0);
    rd(16'h3004, r);           chk(r == 0, "R1 target", r, 0);
    rd(16'h0004, r);           chk(r == 0, "R1 mode", r, 0);
    chk(msiValid == 0, "R1 valid", 32'(msiValid), 0);

    // R2 domain register bits
    wr(16'h0000, 32'hFFFF_FFFF);
    rd(16'h0000, r);           chk(r == 32'h104, "R2", r, 32'h104);

    // R4 / R12 sweep over all sources, junk in unused bits
    for (int n = 1; n <= NSRC; n++) begin
      wr(16'(16'h3000 + 4 * n), tgtVal(n) | 32'h8000_8000 | 32'h0200_0000);
      rd(16'(16'h3000 + 4 * n), r);
      chk(r == tgtVal(n), "R4", r, tgtVal(n));
      wr(16'(4 * n), 32'hFF);
      rd(16'(4 * n), r);
      chk(r == 1, "R12", r, 1);
    end

    // R11 / R5 / R7: event while disabled, then enable by number
    wr(16'h0000, 32'h104);
    for (int n = 1; n <= NSRC; n++) begin
      pulse(NSRC'(1) << (n - 1));
      expectNone("R5 disabled");
      wr(16'h1000, 32'(n));
      expectMsg(n, "R11", n == 1);
      expectNone("R7 once");
    end

    // R3 out-of-range and zero writes, read as zero, clear
    for (int n = 1; n <= NSRC; n++) wr(16'h1004, 32'(n));
    wr(16'h1000, 32'd0);
    wr(16'h1000, 32'(NSRC + 1));
    wr(16'h1000, 32'h100);
    pulse('1);
    expectNone("R3 ignored");
    rd(16'h1000, r);           chk(r == 0, "R3 read set", r, 0);
    rd(16'h1004, r);           chk(r == 0, "R3 read clr", r, 0);
    wr(16'h1000, 32'd3);
    expectMsg(3, "R3 enable", 0);
    wr(16'h1004, 32'd3);
    pulse(8'h04);
    expectNone("R3 cleared");

    // R5 domain gating, R9 ordering of all pending sources
    wr(16'h0000, 32'h100);
    for (int n = 1; n <= NSRC; n++) wr(16'h1000, 32'(n));
    expectNone("R5 mode off");
    wr(16'h0000, 32'h004);
    expectNone("R5 enable off");
    wr(16'h0000, 32'h104);
    for (int n = 1; n <= NSRC; n++) expectMsg(n, "R9 sweep", 0);
    expectNone("R7 drained");

    // R9 simultaneous events
    pulse(8'b0101_0010);
    expectMsg(2, "R9 first", 0);
    expectMsg(5, "R9 second", 0);
    expectMsg(7, "R9 third", 0);

    // R8 level mode on source 4
    wr(16'h0010, 32'h0);
    @(negedge clk); srcIn[3] = 1;
    for (int k = 0; k < 3; k++) expectMsg(4, "R8 repeat", 0);
    srcIn[3] = 0;
    waitMsi(10, got);
    if (got) ack();
    expectNone("R8 quiet");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule